// File: doc/BRIEF.md
# Error Log Bank with Class-Priority Overwrite

This block is a single hardware error-reporting bank. Each error event is presented for one cycle with a 3-bit class code, an address and a syndrome. The first legal event fills the bank. Every later event is arbitrated by class priority. A more severe event replaces the stored address, syndrome and class. An event of equal or lower severity is dropped, and the first record stays.

The status flags are merged across events rather than replaced. The uncorrected, context-corrupt, signal and action-required flags are sticky ORs of what every logged event contributed. Any event after the first raises overflow. A combinational reset-required output tells system software that the logged state cannot be recovered without a reset.

A one-cycle software clear empties the bank. If a clear and a legal event arrive in the same cycle, the event becomes the first record of a freshly emptied bank.

Top module: `err_log_bank`

## Requirements
- R1: After reset, and one cycle after `sw_clear` with no legal event, every status flag is 0. `log_class`, `log_addr` and `log_synd` are also 0.
- R2: The class codes are: 0 corrected, 1 uncorrected no-action, 2 recoverable action-optional, 3 recoverable action-required, 4 fatal with context corrupt. Codes 5 to 7 are ignored and change no output. A legal strobe shows on the outputs after the next rising clock edge.
- R3: The first legal event into an empty bank sets `st_valid` and clears `st_over`. It loads the address, syndrome and class. Its flags come from its class: uc=1 for codes 1 to 4, pcc=1 only for code 4, sig=1 for codes 2 and 3, act=1 only for code 3.
- R4: Every legal event that arrives while `st_valid` is 1 sets `st_over`, whether or not its payload is stored.
- R5: A recoverable event (codes 1 to 3) replaces a stored corrected record. A corrected event never replaces a stored recoverable record. In both orders the result has uc=1 and pcc=0, with sig and act taken from the recoverable event.
- R6: When two recoverable events meet, the first payload is kept. `st_sig` and `st_act` become the OR of both events' contributions.
- R7: A fatal event replaces a stored recoverable record. A recoverable event after a stored fatal record is dropped. Both orders leave uc=1 and pcc=1.
- R8: A corrected event after a stored corrected record keeps the first payload. A fatal event after a stored fatal record also keeps the first payload.
- R9: `st_sig` and `st_act` are sticky. Once set, no later event clears them; only a clear or reset does.
- R10: `reset_req` is 1 exactly when the bank is valid and `st_act` or `st_pcc` is 1. A pair made only of no-action and action-optional events leaves it at 0.
- R11: A clear and a legal event in the same cycle log the event as the first record: `st_over`=0, the new payload is loaded, and the flags come only from the new event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_class | input | 3 | Event class code |
| evt_addr | input | AW | Event address |
| evt_synd | input | SW | Event syndrome |
| sw_clear | input | 1 | Software clear of the whole bank |
| st_valid | output | 1 | Bank holds a record |
| st_over | output | 1 | A second event was seen |
| st_uc | output | 1 | Uncorrected error logged |
| st_pcc | output | 1 | Context corrupt (fatal) logged |
| st_sig | output | 1 | Signalling flag, sticky |
| st_act | output | 1 | Action-required flag, sticky |
| log_class | output | 3 | Class of the stored record |
| log_addr | output | AW | Stored address |
| log_synd | output | SW | Stored syndrome |
| reset_req | output | 1 | System reset required |

## Verification
The bench walks through each ordered pair of classes that the priority rule separates: corrected then recoverable, recoverable then corrected, two recoverables, recoverable then fatal, and the reverse of that last pair.

A design that compared severity the wrong way would report the wrong address for a dropped or replacing event. One that copied the new event's flags instead of merging them would lose the action flag and drop `reset_req` in mid-log.

The bench also drives reserved codes, which must not set overflow, and a clear in the same cycle as an event. A design that let the clear win would leave the bank empty and lose the error.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

  typedef enum logic [2:0] {
    CLS_CORR  = 3'd0,
    CLS_UNA   = 3'd1,
    CLS_OPT   = 3'd2,
    CLS_REQ   = 3'd3,
    CLS_FATAL = 3'd4
  } err_class_e;

  localparam int RANK_W = 2;

  typedef struct packed {
    logic              legal;
    logic [RANK_W-1:0] rank;
    logic              uc;
    logic              pcc;
    logic              sig;
    logic              act;
  } evt_info_t;

  typedef struct packed {
    logic       valid;
    logic       over;
    logic       uc;
    logic       pcc;
    logic       sig;
    logic       act;
    logic [2:0] cls;
  } bank_flags_t;

  // Severity: corrected 0, recoverable 1, fatal 2.
  function automatic logic [RANK_W-1:0] rank_of(input logic [2:0] code);
    case (code)
      CLS_CORR:                 rank_of = 2'd0;
      CLS_UNA, CLS_OPT, CLS_REQ: rank_of = 2'd1;
      CLS_FATAL:                rank_of = 2'd2;
      default:                  rank_of = 2'd0;
    endcase
  endfunction

  function automatic evt_info_t decode_class(input logic [2:0] code);
    evt_info_t r;
    r.legal = (code <= CLS_FATAL);
    r.rank  = rank_of(code);
    r.uc    = r.legal && (code != CLS_CORR);
    r.pcc   = (code == CLS_FATAL);
    r.sig   = (code == CLS_OPT) || (code == CLS_REQ);
    r.act   = (code == CLS_REQ);
    return r;
  endfunction

  function automatic logic outranks(input logic [2:0] new_code, input logic [2:0] old_code);
    return rank_of(new_code) > rank_of(old_code);
  endfunction

endpackage

// File: rtl/elb_decode.sv
module elb_decode
  import err_log_pkg::*;
(
  input  logic [2:0] code,
  output evt_info_t  info
);
  always_comb info = decode_class(code);
endmodule

// File: rtl/elb_merge.sv
module elb_merge
  import err_log_pkg::*;
(
  input  bank_flags_t base,
  input  evt_info_t   info,
  input  logic [2:0]  code,
  output bank_flags_t next,
  output logic        replace
);
  always_comb begin
    replace    = !base.valid || outranks(code, base.cls);
    next.valid = 1'b1;
    next.over  = base.valid;
    next.uc    = base.uc  | info.uc;
    next.pcc   = base.pcc | info.pcc;
    next.sig   = base.sig | info.sig;
    next.act   = base.act | info.act;
    next.cls   = replace ? code : base.cls;
  end
endmodule

// File: rtl/elb_payload_reg.sv
module elb_payload_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
    else if (clr)  q <= '0;
  end
endmodule

// File: rtl/err_log_bank.sv
module err_log_bank
  import err_log_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [2:0]    evt_class,
  input  logic [AW-1:0] evt_addr,
  input  logic [SW-1:0] evt_synd,
  input  logic          sw_clear,
  output logic          st_valid,
  output logic          st_over,
  output logic          st_uc,
  output logic          st_pcc,
  output logic          st_sig,
  output logic          st_act,
  output logic [2:0]    log_class,
  output logic [AW-1:0] log_addr,
  output logic [SW-1:0] log_synd,
  output logic          reset_req
);
  localparam int PW = AW + SW;

  bank_flags_t flags_q, base, next;
  evt_info_t   info;
  logic        replace;

  // Named internal events, observed by the checker.
  logic evt_accept;
  logic evt_is_ce;
  logic clear_only;
  logic pay_load;

  elb_decode u_dec (.code(evt_class), .info(info));

  assign evt_accept = evt_valid && info.legal;
  assign evt_is_ce  = evt_accept && (evt_class == CLS_CORR);
  assign clear_only = sw_clear && !evt_accept;
  assign base       = sw_clear ? '0 : flags_q;

  elb_merge u_merge (
    .base(base), .info(info), .code(evt_class), .next(next), .replace(replace)
  );

  assign pay_load = evt_accept && replace;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_q <= '0;
    else if (evt_accept) flags_q <= next;
    else if (sw_clear)   flags_q <= '0;
  end

  logic [PW-1:0] pay_q;
  elb_payload_reg #(.W(PW)) u_pay (
    .clk(clk), .rst_n(rst_n), .clr(clear_only), .load(pay_load),
    .d({evt_addr, evt_synd}), .q(pay_q)
  );

  assign st_valid  = flags_q.valid;
  assign st_over   = flags_q.over;
  assign st_uc     = flags_q.uc;
  assign st_pcc    = flags_q.pcc;
  assign st_sig    = flags_q.sig;
  assign st_act    = flags_q.act;
  assign log_class = flags_q.cls;
  assign log_addr  = pay_q[PW-1:SW];
  assign log_synd  = pay_q[SW-1:0];
  assign reset_req = flags_q.valid && (flags_q.act || flags_q.pcc);

endmodule

// File: rtl/err_log_bank_chk.sv
module err_log_bank_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_clear,
  input logic          evt_valid,
  input logic          evt_accept,
  input logic          evt_is_ce,
  input logic          st_valid,
  input logic          st_over,
  input logic          st_uc,
  input logic          st_pcc,
  input logic          st_sig,
  input logic          st_act,
  input logic [AW-1:0] log_addr,
  input logic          reset_req
);
  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && evt_accept && !sw_clear) |=> st_over);

  a_r9_sig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sig && !sw_clear) |=> st_sig);

  a_r9_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_act && !sw_clear) |=> st_act);

  a_r5_ce_no_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_uc && evt_is_ce && !sw_clear) |=> $stable(log_addr));

  a_r7_fatal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pcc && !sw_clear) |=> (st_pcc && st_uc && reset_req));

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !evt_valid) |=> (!st_valid && !st_over && !reset_req));

  a_r2_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_accept && !sw_clear) |=> ($stable(st_valid) && $stable(st_over) && $stable(log_addr)));

  a_r11_clear_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && evt_accept) |=> (st_valid && !st_over));
endmodule

bind err_log_bank err_log_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_clear(sw_clear), .evt_valid(evt_valid),
  .evt_accept(evt_accept), .evt_is_ce(evt_is_ce), .st_valid(st_valid),
  .st_over(st_over), .st_uc(st_uc), .st_pcc(st_pcc), .st_sig(st_sig),
  .st_act(st_act), .log_addr(log_addr), .reset_req(reset_req)
);

// File: tb/err_log_bank_tb.sv
module err_log_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic [2:0]    evt_class = '0;
  logic [AW-1:0] evt_addr = '0;
  logic [SW-1:0] evt_synd = '0;
  logic          sw_clear = 1'b0;
  logic st_valid, st_over, st_uc, st_pcc, st_sig, st_act, reset_req;
  logic [2:0]    log_class;
  logic [AW-1:0] log_addr;
  logic [SW-1:0] log_synd;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_log_bank #(.AW(AW), .SW(SW)) u_dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one event, or a clear, or both, for one cycle. It returns on the
  // next falling edge, after the registering rising edge.
  task automatic pulse(input bit ev, input logic [2:0] c, input logic [AW-1:0] a,
                       input logic [SW-1:0] s, input bit clr);
    @(negedge clk);
    evt_valid = ev; evt_class = c; evt_addr = a; evt_synd = s; sw_clear = clr;
    @(negedge clk);
    evt_valid = 1'b0; sw_clear = 1'b0;
  endtask

  task automatic clear_bank();
    pulse(1'b0, 3'd0, '0, '0, 1'b1);
  endtask

  task automatic expect_bank(input string req, input bit v, input bit ov, input bit uc,
                             input bit pcc, input bit sg, input bit ac, input logic [2:0] cls,
                             input logic [AW-1:0] a, input logic [SW-1:0] s);
    chk(req, "valid", 64'(st_valid), 64'(v));
    chk(req, "over", 64'(st_over), 64'(ov));
    chk(req, "uc", 64'(st_uc), 64'(uc));
    chk(req, "pcc", 64'(st_pcc), 64'(pcc));
    chk(req, "sig", 64'(st_sig), 64'(sg));
    chk(req, "act", 64'(st_act), 64'(ac));
    chk(req, "class", 64'(log_class), 64'(cls));
    chk(req, "addr", 64'(log_addr), 64'(a));
    chk(req, "synd", 64'(log_synd), 64'(s));
    chk("R10", "reset_req", 64'(reset_req), 64'(v && (ac || pcc)));
  endtask

  task automatic t_reset();
    expect_bank("R1", 0, 0, 0, 0, 0, 0, 3'd0, '0, '0);
  endtask

  task automatic t_recoverable_pairs();
    pulse(1, 3'd1, 32'h1000, 16'h0011, 0);
    expect_bank("R3", 1, 0, 1, 0, 0, 0, 3'd1, 32'h1000, 16'h0011);
    pulse(1, 3'd2, 32'h2000, 16'h0022, 0);
    expect_bank("R6", 1, 1, 1, 0, 1, 0, 3'd1, 32'h1000, 16'h0011);
    chk("R10", "no-action+optional", 64'(reset_req), 64'd0);
    pulse(1, 3'd3, 32'h3000, 16'h0033, 0);
    expect_bank("R6", 1, 1, 1, 0, 1, 1, 3'd1, 32'h1000, 16'h0011);
    clear_bank();
    expect_bank("R1", 0, 0, 0, 0, 0, 0, 3'd0, '0, '0);
  endtask

  task automatic t_ce_vs_recoverable();
    pulse(1, 3'd0, 32'hC0, 16'h00C0, 0);
    expect_bank("R3", 1, 0, 0, 0, 0, 0, 3'd0, 32'hC0, 16'h00C0);
    pulse(1, 3'd3, 32'hA1, 16'h00A1, 0);
    expect_bank("R5", 1, 1, 1, 0, 1, 1, 3'd3, 32'hA1, 16'h00A1);
    clear_bank();
    pulse(1, 3'd3, 32'hB1, 16'h00B1, 0);
    pulse(1, 3'd0, 32'hB2, 16'h00B2, 0);
    expect_bank("R5", 1, 1, 1, 0, 1, 1, 3'd3, 32'hB1, 16'h00B1);
    pulse(1, 3'd1, 32'hB3, 16'h00B3, 0);
    expect_bank("R9", 1, 1, 1, 0, 1, 1, 3'd3, 32'hB1, 16'h00B1);
    clear_bank();
  endtask

  task automatic t_fatal();
    pulse(1, 3'd2, 32'hD1, 16'h00D1, 0);
    pulse(1, 3'd4, 32'hD2, 16'h00D2, 0);
    expect_bank("R7", 1, 1, 1, 1, 1, 0, 3'd4, 32'hD2, 16'h00D2);
    pulse(1, 3'd3, 32'hD3, 16'h00D3, 0);
    expect_bank("R7", 1, 1, 1, 1, 1, 1, 3'd4, 32'hD2, 16'h00D2);
    clear_bank();
    pulse(1, 3'd4, 32'hE1, 16'h00E1, 0);
    expect_bank("R3", 1, 0, 1, 1, 0, 0, 3'd4, 32'hE1, 16'h00E1);
    pulse(1, 3'd4, 32'hE2, 16'h00E2, 0);
    expect_bank("R8", 1, 1, 1, 1, 0, 0, 3'd4, 32'hE1, 16'h00E1);
    clear_bank();
  endtask

  task automatic t_ce_pair();
    pulse(1, 3'd0, 32'hF1, 16'h00F1, 0);
    pulse(1, 3'd0, 32'hF2, 16'h00F2, 0);
    expect_bank("R8", 1, 1, 0, 0, 0, 0, 3'd0, 32'hF1, 16'h00F1);
    clear_bank();
  endtask

  task automatic t_reserved_codes();
    for (int c = 5; c < 8; c++) begin
      pulse(1, 3'(c), 32'h55, 16'h0055, 0);
      expect_bank("R2", 0, 0, 0, 0, 0, 0, 3'd0, '0, '0);
    end
    pulse(1, 3'd0, 32'h66, 16'h0066, 0);
    pulse(1, 3'd7, 32'h77, 16'h0077, 0);
    expect_bank("R2", 1, 0, 0, 0, 0, 0, 3'd0, 32'h66, 16'h0066);
  endtask

  task automatic t_clear_with_event();
    pulse(1, 3'd3, 32'h90, 16'h0090, 0);
    pulse(1, 3'd1, 32'h91, 16'h0091, 1);
    expect_bank("R11", 1, 0, 1, 0, 0, 0, 3'd1, 32'h91, 16'h0091);
    clear_bank();
    expect_bank("R1", 0, 0, 0, 0, 0, 0, 3'd0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_recoverable_pairs();
    t_ce_vs_recoverable();
    t_fatal();
    t_ce_pair();
    t_reserved_codes();
    t_clear_with_event();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule